// File: doc/BRIEF.md
# In-Order Integer Pipeline with Memory Stall

This block is a four-stage in-order integer pipeline. Instructions arrive from an instruction queue through a valid/take handshake. The decode stage splits each instruction into fields. The execute stage reads its operands from an external register file, which may refuse the read. ALU operations are resolved in execute and go straight to writeback. Load-word and store-word operations compute their effective address in execute. They are then handed to a cache-access stage, which talks to a memory port through a request/grant handshake and, for loads, a separate data-valid return.

The cache-access stage holds a store request until memory grants it. It holds a load until the returned data arrives. While it waits, the execute stage freezes, and decode freezes behind it. The writeback stage presents its results to the register file on two independent write ports, one for ALU results and one for loaded data. Both ports can be active in the same cycle. A three-bit condition register tracks the sign of the most recent ALU result.

Top module: `ipipe_core`

## Requirements
- R1: While reset is high and in the cycle after it, the outputs `wb_a_en`, `wb_m_en` and `mem_req` are low and `cr` is zero. Reset is synchronous and active high, and it empties every stage.
- R2: Instruction format: opcode in [31:26], destination in [25:21], first source in [20:16], second source in [15:11], and a 16-bit sign-extended immediate in [15:0]. Opcode 1 is add, 2 is sub, 3 is and, 4 is or and 5 is add-immediate. Each writes its result to the destination index on the ALU write port.
- R3: Each ALU result updates `cr` in the same cycle it appears on the ALU write port. The bits are `cr[2]` for less than zero (signed), `cr[1]` for greater than zero and `cr[0]` for equal to zero. In a cycle with no ALU result, `cr` keeps its value.
- R4: `iq_take` is high only when decode is empty or its instruction moves on in that cycle. Every taken instruction takes effect exactly once. Results of a given kind appear in program order.
- R5: An opcode of 0 or above 7 is taken from the queue and then dropped. It causes no write, no memory request and no change to `cr`.
- R6: A load (opcode 6) requests memory with `mem_we` low at address source1 + immediate. One cycle after `mem_rvalid` is high, the returned data appears on the load write port with the load's destination index. `mem_rvalid` counts only for a load whose request was granted earlier or in the same cycle.
- R7: A store (opcode 7) requests memory with `mem_we` high, at address source1 + immediate, with the data of the register named in [25:21]. It is granted exactly once.
- R8: While `mem_req` is high and `mem_gnt` is low, the request is still present in the next cycle, with `mem_we`, `mem_addr` and `mem_wdata` unchanged.
- R9: In a cycle where `rf_rd_req` is high and `rf_rd_ok` is low, execute does not advance, so `wb_a_en` is low in the next cycle.
- R10: While the cache-access stage waits for a grant or for load data, execute does not advance, so no ALU result retires behind a waiting memory operation.
- R11: An ALU result and a load result can both be written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_valid | input | 1 | Queue offers an instruction |
| iq_instr | input | 32 | Offered instruction word |
| iq_take | output | 1 | Decode takes the offered instruction this cycle |
| rf_rd_req | output | 1 | Execute wants its two source operands |
| rf_a_idx | output | 5 | First source register index |
| rf_b_idx | output | 5 | Second source index ([15:11] for ALU register forms, [25:21] otherwise) |
| rf_rd_ok | input | 1 | Register file serves the read this cycle |
| rf_a_data | input | DW | First operand value |
| rf_b_data | input | DW | Second operand value |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DW | Effective address |
| mem_wdata | output | DW | Store data |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Load data is valid |
| mem_rdata | input | DW | Load data |
| wb_a_en | output | 1 | ALU result write enable |
| wb_a_idx | output | 5 | ALU result register index |
| wb_a_data | output | DW | ALU result value |
| wb_m_en | output | 1 | Load result write enable |
| wb_m_idx | output | 5 | Load result register index |
| wb_m_data | output | DW | Load result value |
| cr | output | 3 | Condition register {lt, gt, eq} |

## Verification
The two functions that can land in one cycle are load completion and ALU retirement. When load data returns, the cache-access stage frees up, and the ALU instruction that was frozen behind it retires at the same edge. The bench provokes this with loads followed directly by register-form ALU instructions. Memory returns data after a random delay, and in a directed opening phase it grants and returns at once. Each write port is checked on its own against a separate in-order queue of expected results, and the run must record at least one cycle with both ports active.

// File: rtl/ipipe_pkg.sv
package ipipe_pkg;

  localparam int ILEN = 32;
  localparam int OPW  = 6;
  localparam int RIW  = 5;
  localparam int IMW  = 16;
  localparam int CRW  = 3;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 6'd0,
    OP_ADD  = 6'd1,
    OP_SUB  = 6'd2,
    OP_AND  = 6'd3,
    OP_OR   = 6'd4,
    OP_ADDI = 6'd5,
    OP_LW   = 6'd6,
    OP_SW   = 6'd7
  } opc_e;

  typedef struct packed {
    logic             vld;
    opc_e             op;
    logic [RIW-1:0]   rd;
    logic [RIW-1:0]   rs;
    logic [RIW-1:0]   rt;
    logic [IMW-1:0]   imm;
  } uop_t;

  function automatic logic op_legal(input logic [OPW-1:0] o);
    return (o >= 6'd1) && (o <= 6'd7);
  endfunction

  function automatic logic op_is_mem(input opc_e o);
    return (o == OP_LW) || (o == OP_SW);
  endfunction

  function automatic logic op_reg_form(input opc_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_AND) || (o == OP_OR);
  endfunction

endpackage

// File: rtl/ipipe_decode.sv
module ipipe_decode
  import ipipe_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            iq_valid,
  input  logic [ILEN-1:0] iq_instr,
  output logic            iq_take,
  input  logic            ex_ready,
  output uop_t            d_uop
);

  uop_t d_q;
  logic [OPW-1:0] raw_op;

  assign raw_op  = iq_instr[ILEN-1 -: OPW];
  assign iq_take = iq_valid && (!d_q.vld || ex_ready);
  assign d_uop   = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= '0;
    end else if (iq_take) begin
      d_q.vld <= op_legal(raw_op);
      d_q.op  <= opc_e'(raw_op);
      d_q.rd  <= iq_instr[25:21];
      d_q.rs  <= iq_instr[20:16];
      d_q.rt  <= iq_instr[15:11];
      d_q.imm <= iq_instr[IMW-1:0];
    end else if (ex_ready) begin
      d_q.vld <= 1'b0;
    end
  end

  // R4
  dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (d_q.vld && !ex_ready) |=> $stable(d_q));

endmodule

// File: rtl/ipipe_exec.sv
module ipipe_exec
  import ipipe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  uop_t           d_uop,
  output logic           ex_ready,
  output logic           rf_rd_req,
  output logic [RIW-1:0] rf_a_idx,
  output logic [RIW-1:0] rf_b_idx,
  input  logic           rf_rd_ok,
  input  logic [DW-1:0]  rf_a_data,
  input  logic [DW-1:0]  rf_b_data,
  input  logic           c_stall,
  output logic           alu_go,
  output logic [RIW-1:0] alu_rd,
  output logic [DW-1:0]  alu_res,
  output logic           mem_go,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [RIW-1:0] mem_rd,
  output logic [CRW-1:0] cr
);

  localparam int EXTW = DW - IMW;

  uop_t          e_q;
  logic          adv;
  logic          is_mem;
  logic [DW-1:0] imm_x;
  logic [DW-1:0] opb;

  assign is_mem    = op_is_mem(e_q.op);
  assign imm_x     = {{EXTW{e_q.imm[IMW-1]}}, e_q.imm};
  assign opb       = op_reg_form(e_q.op) ? rf_b_data : imm_x;

  assign rf_rd_req = e_q.vld;
  assign rf_a_idx  = e_q.rs;
  assign rf_b_idx  = op_reg_form(e_q.op) ? e_q.rt : e_q.rd;

  // Execute freezes on a refused read or on any cache-access wait.
  assign adv       = e_q.vld && rf_rd_ok && !c_stall;
  assign ex_ready  = !e_q.vld || adv;

  always_comb begin
    case (e_q.op)
      OP_SUB:  alu_res = rf_a_data - opb;
      OP_AND:  alu_res = rf_a_data & opb;
      OP_OR:   alu_res = rf_a_data | opb;
      default: alu_res = rf_a_data + opb;
    endcase
  end

  assign alu_go    = adv && !is_mem;
  assign alu_rd    = e_q.rd;
  assign mem_go    = adv && is_mem;
  assign mem_we    = (e_q.op == OP_SW);
  assign mem_addr  = rf_a_data + imm_x;
  assign mem_wdata = rf_b_data;
  assign mem_rd    = e_q.rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_q <= '0;
    end else if (ex_ready) begin
      e_q <= d_uop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr <= '0;
    end else if (alu_go) begin
      cr <= {$signed(alu_res) < 0, $signed(alu_res) > 0, alu_res == '0};
    end
  end

  // R10
  ex_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (e_q.vld && c_stall) |=> $stable(e_q));

endmodule

// File: rtl/ipipe_cacc.sv
module ipipe_cacc
  import ipipe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           we_in,
  input  logic [DW-1:0]  addr_in,
  input  logic [DW-1:0]  wdata_in,
  input  logic [RIW-1:0] rd_in,
  output logic           c_stall,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           ld_go,
  output logic [RIW-1:0] ld_rd,
  output logic [DW-1:0]  ld_data
);

  logic           c_vld;
  logic           c_we;
  logic [RIW-1:0] c_rd;
  logic           req_q;
  logic [DW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           done;

  assign done = c_vld && (c_we ? (req_q && mem_gnt)
                               : (mem_rvalid && (!req_q || mem_gnt)));
  assign c_stall   = c_vld && !done;

  assign mem_req   = req_q;
  assign mem_we    = c_we;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  assign ld_go   = done && !c_we;
  assign ld_rd   = c_rd;
  assign ld_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_vld   <= 1'b0;
      c_we    <= 1'b0;
      c_rd    <= '0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (go) begin
      c_vld   <= 1'b1;
      c_we    <= we_in;
      c_rd    <= rd_in;
      req_q   <= 1'b1;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end else if (done) begin
      c_vld   <= 1'b0;
      req_q   <= 1'b0;
    end else if (req_q && mem_gnt) begin
      req_q   <= 1'b0;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R7
  st_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_gnt) |-> !c_stall);

  // R6
  ld_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (c_vld && !c_we && !mem_rvalid) |-> c_stall);

endmodule

// File: rtl/ipipe_core.sv
module ipipe_core
  import ipipe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iq_valid,
  input  logic [ILEN-1:0] iq_instr,
  output logic            iq_take,
  output logic            rf_rd_req,
  output logic [RIW-1:0]  rf_a_idx,
  output logic [RIW-1:0]  rf_b_idx,
  input  logic            rf_rd_ok,
  input  logic [DW-1:0]   rf_a_data,
  input  logic [DW-1:0]   rf_b_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            wb_a_en,
  output logic [RIW-1:0]  wb_a_idx,
  output logic [DW-1:0]   wb_a_data,
  output logic            wb_m_en,
  output logic [RIW-1:0]  wb_m_idx,
  output logic [DW-1:0]   wb_m_data,
  output logic [CRW-1:0]  cr
);

  uop_t           d_uop;
  logic           ex_ready;
  logic           c_stall;
  logic           alu_go;
  logic [RIW-1:0] alu_rd;
  logic [DW-1:0]  alu_res;
  logic           m_go;
  logic           m_we;
  logic [DW-1:0]  m_addr;
  logic [DW-1:0]  m_wdata;
  logic [RIW-1:0] m_rd;
  logic           ld_go;
  logic [RIW-1:0] ld_rd;
  logic [DW-1:0]  ld_data;

  ipipe_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .iq_valid (iq_valid),
    .iq_instr (iq_instr),
    .iq_take  (iq_take),
    .ex_ready (ex_ready),
    .d_uop    (d_uop)
  );

  ipipe_exec #(.DW(DW)) u_ex (
    .clk       (clk),
    .rst       (rst),
    .d_uop     (d_uop),
    .ex_ready  (ex_ready),
    .rf_rd_req (rf_rd_req),
    .rf_a_idx  (rf_a_idx),
    .rf_b_idx  (rf_b_idx),
    .rf_rd_ok  (rf_rd_ok),
    .rf_a_data (rf_a_data),
    .rf_b_data (rf_b_data),
    .c_stall   (c_stall),
    .alu_go    (alu_go),
    .alu_rd    (alu_rd),
    .alu_res   (alu_res),
    .mem_go    (m_go),
    .mem_we    (m_we),
    .mem_addr  (m_addr),
    .mem_wdata (m_wdata),
    .mem_rd    (m_rd),
    .cr        (cr)
  );

  ipipe_cacc #(.DW(DW)) u_ca (
    .clk        (clk),
    .rst        (rst),
    .go         (m_go),
    .we_in      (m_we),
    .addr_in    (m_addr),
    .wdata_in   (m_wdata),
    .rd_in      (m_rd),
    .c_stall    (c_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .ld_go      (ld_go),
    .ld_rd      (ld_rd),
    .ld_data    (ld_data)
  );

  // Writeback latch: two independent slots, refilled every cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_a_en   <= 1'b0;
      wb_a_idx  <= '0;
      wb_a_data <= '0;
      wb_m_en   <= 1'b0;
      wb_m_idx  <= '0;
      wb_m_data <= '0;
    end else begin
      wb_a_en <= alu_go;
      wb_m_en <= ld_go;
      if (alu_go) begin
        wb_a_idx  <= alu_rd;
        wb_a_data <= alu_res;
      end
      if (ld_go) begin
        wb_m_idx  <= ld_rd;
        wb_m_data <= ld_data;
      end
    end
  end

  // R3
  cr_value_chk: assert property (@(posedge clk) disable iff (rst)
    wb_a_en |-> (cr == {$signed(wb_a_data) < 0, $signed(wb_a_data) > 0,
                        wb_a_data == '0}));

  // R3
  cr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_a_en |-> $stable(cr));

  // R9
  rf_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_rd_req && !rf_rd_ok) |=> !wb_a_en);

  // R10
  mem_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> !wb_a_en);

endmodule

// File: tb/ipipe_core_test.sv
module ipipe_core_test;

  localparam int DW    = 32;
  localparam int NPROG = 300;
  localparam int NFAST = 40;
  localparam int QD    = 512;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst;
  logic iq_valid;
  logic [31:0] iq_instr;
  logic iq_take;
  logic rf_rd_req;
  logic [4:0] rf_a_idx, rf_b_idx;
  logic rf_rd_ok;
  logic [DW-1:0] rf_a_data, rf_b_data;
  logic mem_req, mem_we;
  logic [DW-1:0] mem_addr, mem_wdata;
  logic mem_gnt, mem_rvalid;
  logic [DW-1:0] mem_rdata;
  logic wb_a_en, wb_m_en;
  logic [4:0] wb_a_idx, wb_m_idx;
  logic [DW-1:0] wb_a_data, wb_m_data;
  logic [2:0] cr;

  always #10 clk = ~clk;

  logic [31:0] regs [32];
  logic [31:0] prog [NPROG];

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [2:0] cr_of(input logic [31:0] d);
    return {$signed(d) < 0, $signed(d) > 0, d == 32'd0};
  endfunction

  function automatic logic [31:0] mk(input int op, input int rd, input int rs,
                                     input int rt, input int imm);
    logic [31:0] w;
    w = {op[5:0], rd[4:0], rs[4:0], 16'd0};
    if (op == 5 || op == 6 || op == 7) w[15:0] = imm[15:0];
    else w[15:11] = rt[4:0];
    return w;
  endfunction

  assign rf_a_data = rf_rd_ok ? regs[rf_a_idx] : 32'hDEAD_BEEF;
  assign rf_b_data = rf_rd_ok ? regs[rf_b_idx] : 32'hBAAD_F00D;
  assign mem_rdata = mem_rvalid ? mem_val(mem_addr) : 32'h0;

  ipipe_core #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .iq_valid(iq_valid), .iq_instr(iq_instr),
    .iq_take(iq_take), .rf_rd_req(rf_rd_req), .rf_a_idx(rf_a_idx),
    .rf_b_idx(rf_b_idx), .rf_rd_ok(rf_rd_ok), .rf_a_data(rf_a_data),
    .rf_b_data(rf_b_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wb_a_en(wb_a_en),
    .wb_a_idx(wb_a_idx), .wb_a_data(wb_a_data), .wb_m_en(wb_m_en),
    .wb_m_idx(wb_m_idx), .wb_m_data(wb_m_data), .cr(cr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [4:0]  aq_idx [QD];
  logic [31:0] aq_dat [QD];
  logic [4:0]  lq_idx [QD];
  logic [31:0] lq_dat [QD];
  logic [31:0] sq_adr [QD];
  logic [31:0] sq_dat [QD];
  int ah = 0, at = 0, lh = 0, lt = 0, sh = 0, st = 0;
  int n_illegal = 0;

  // Expected effects of one instruction, from the R2/R5/R6/R7 encoding.
  task automatic expect_instr(input logic [31:0] w);
    logic [5:0]  op;
    logic [31:0] a, b, ix, r;
    op = w[31:26];
    ix = {{16{w[15]}}, w[15:0]};
    a  = regs[w[20:16]];
    b  = (op >= 6'd1 && op <= 6'd4) ? regs[w[15:11]] : ix;
    case (op)
      6'd1: r = a + b;
      6'd2: r = a - b;
      6'd3: r = a & b;
      6'd4: r = a | b;
      6'd5: r = a + b;
      default: r = 32'd0;
    endcase
    if (op >= 6'd1 && op <= 6'd5) begin
      aq_idx[at % QD] = w[25:21]; aq_dat[at % QD] = r; at++;
    end else if (op == 6'd6) begin
      lq_idx[lt % QD] = w[25:21]; lq_dat[lt % QD] = mem_val(a + ix); lt++;
    end else if (op == 6'd7) begin
      sq_adr[st % QD] = a + ix; sq_dat[st % QD] = regs[w[25:21]]; st++;
    end else begin
      n_illegal++;
    end
  endtask

  initial begin
    int ptr, cyc, dual, n_ref, pend;
    bit prev_rv, prev_lacc, prev_ref, prev_cst, fast, finished;
    logic [2:0]  last_cr;
    logic [31:0] prev_addr;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) regs[i] = $urandom;
    regs[3] = 32'd0;
    regs[4] = 32'hFFFF_FFF0;
    // directed opening: eq, lt, gt results, illegal ops, load then ALU pairs
    prog[0] = mk(2, 1, 7, 7, 0);
    prog[1] = mk(5, 2, 3, 0, -5);
    prog[2] = mk(5, 5, 3, 0, 9);
    prog[3] = mk(0, 6, 1, 2, 0);
    prog[4] = mk(6, 8, 9, 0, 16);
    prog[5] = mk(1, 9, 10, 11, 0);
    prog[6] = mk(7, 12, 4, 0, -4);
    prog[7] = mk(63, 1, 1, 1, 0);
    prog[8] = mk(6, 13, 3, 0, 32);
    prog[9] = mk(3, 14, 15, 16, 0);
    prog[10] = mk(4, 17, 3, 3, 0);
    for (int i = 11; i < NPROG; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) prog[i] = mk(8 + ($urandom % 56), $urandom, $urandom, $urandom, $urandom);
      else prog[i] = mk((r % 7) + 1, $urandom, $urandom, $urandom, $urandom);
    end

    rst = 1'b1; iq_valid = 1'b0; iq_instr = '0; rf_rd_ok = 1'b0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!wb_a_en && !wb_m_en, "R1 writes idle in reset", {wb_a_en, wb_m_en}, 0);
    chk(!mem_req, "R1 no memory request in reset", mem_req, 0);
    chk(cr == 3'b000, "R1 cr cleared", cr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!wb_a_en && !wb_m_en && !mem_req && cr == 0, "R1 idle after reset",
        {wb_a_en, wb_m_en, mem_req, cr}, 0);

    ptr = 0; cyc = 0; dual = 0; n_ref = 0; pend = 0;
    prev_rv = 0; prev_lacc = 0; prev_ref = 0; prev_cst = 0; finished = 0;
    last_cr = cr; prev_addr = '0;

    while (cyc < LIMIT) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      // results of the last edge
      if (wb_a_en) begin
        if (ah == at) chk(0, "R4 unexpected ALU write", wb_a_data, 0);
        else begin
          chk(wb_a_idx == aq_idx[ah % QD], "R2 ALU destination", wb_a_idx, aq_idx[ah % QD]);
          chk(wb_a_data == aq_dat[ah % QD], "R2 ALU result", wb_a_data, aq_dat[ah % QD]);
          chk(cr == cr_of(aq_dat[ah % QD]), "R3 cr from result", cr, cr_of(aq_dat[ah % QD]));
          ah++;
        end
      end else begin
        chk(cr == last_cr, "R3 cr held without ALU result", cr, last_cr);
      end
      last_cr = cr;
      if (wb_m_en) begin
        if (lh == lt) chk(0, "R6 unexpected load write", wb_m_data, 0);
        else begin
          chk(wb_m_idx == lq_idx[lh % QD], "R6 load destination", wb_m_idx, lq_idx[lh % QD]);
          chk(wb_m_data == lq_dat[lh % QD], "R6 load data", wb_m_data, lq_dat[lh % QD]);
          lh++;
        end
      end
      if (wb_a_en && wb_m_en) dual++;
      if (prev_ref) chk(!wb_a_en, "R9 no retire after refused read", wb_a_en, 0);
      if (prev_cst) begin
        chk(!wb_a_en, "R10 no ALU retire while memory waits", wb_a_en, 0);
        chk(mem_req && mem_addr == prev_addr, "R8 request held", mem_addr, prev_addr);
      end
      if (ptr == NPROG && ah == at && lh == lt && sh == st && !mem_req) begin
        finished = 1;
        break;
      end

      // memory model state
      if (prev_rv) pend = 0;
      else if (prev_lacc) pend = 1;

      // drive next inputs
      fast = (ptr < NFAST);
      rf_rd_ok = fast ? 1'b1 : (($urandom % 4) != 0);
      mem_gnt  = fast ? 1'b1 : (($urandom % 3) != 0);
      mem_rvalid = (pend != 0 || (mem_req && !mem_we && mem_gnt)) &&
                   (fast || ($urandom % 3) == 0);
      iq_valid = (ptr < NPROG) && (fast || ($urandom % 4) != 0);
      iq_instr = (ptr < NPROG) ? prog[ptr] : 32'h0;
      #1;
      if (iq_take && !iq_valid) chk(0, "R4 take without offer", iq_take, 0);
      if (iq_valid && iq_take) begin
        expect_instr(prog[ptr]);
        ptr++;
      end
      if (mem_req && mem_we && mem_gnt) begin
        if (sh == st) chk(0, "R7 unexpected store", mem_addr, 0);
        else begin
          chk(mem_addr == sq_adr[sh % QD], "R7 store address", mem_addr, sq_adr[sh % QD]);
          chk(mem_wdata == sq_dat[sh % QD], "R7 store data", mem_wdata, sq_dat[sh % QD]);
          sh++;
        end
      end
      if (rf_rd_req && !rf_rd_ok) n_ref++;
      prev_rv   = mem_rvalid;
      prev_lacc = mem_req && !mem_we && mem_gnt && !mem_rvalid;
      prev_ref  = rf_rd_req && !rf_rd_ok;
      prev_cst  = mem_req && !mem_gnt;
      prev_addr = mem_addr;
    end

    if (!finished) chk(0, "R4 watchdog: pipeline did not drain", ptr, NPROG);
    chk(ptr == NPROG, "R4 all instructions taken", ptr, NPROG);
    chk(ah == at && lh == lt && sh == st, "R4 every effect seen once",
        ah + lh + sh, at + lt + st);
    chk(n_illegal >= 2, "R5 illegal opcodes dropped without effect", n_illegal, 2);
    chk(dual > 0, "R11 dual writeback in one cycle", dual, 1);
    chk(n_ref > 0, "R9 refused reads exercised", n_ref, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule